// File: doc/BRIEF.md
# Windowed Vertical Countdown Sync Processor

This block derives all vertical timing of a raster display from a master clock that runs at 32 times the line rate, so no free-running vertical oscillator is needed. A prescaler divides the master clock by 16 to make a half-line (2H) tick. A toggle stage halves that tick again to give a 50% duty horizontal square wave. A 10-bit counter counts 2H ticks, so the field length is always a whole number of half lines and interlace is preserved.

A digitised vertical sync input passes through a two-flop synchroniser and a rising-edge detector. A rising edge is honoured only while the count lies inside an acceptance window, from 510 to 574. An accepted edge is held in a pending flag, and the counter resets on the next 2H tick. If no edge has been accepted when the count reaches 574, the counter resets itself on that count's tick. Each reset, whatever its cause, gives a one-clock reset pulse and starts a retrace interval that lasts a set number of 2H ticks. A status output tells whether the latest reset came from sync or was forced.

Top module: `vsync_countdown`

## Requirements
- R1: `tick_2h` is a one-clock pulse that recurs every PRE_DIV (16) clocks.
- R2: `h_out` is a square wave with period 2*PRE_DIV clocks and 50% duty. It changes state only in the clock after a `tick_2h` pulse.
- R3: While and after synchronous active-high `rst`, with no tick yet, `tick_2h`, `h_out`, `v_reset`, `retrace` and `sync_src` are all 0.
- R4: With no accepted sync, the counter resets on the tick taken at count WIN_CLOSE (574). Successive `v_reset` pulses are then (WIN_CLOSE+1)*PRE_DIV = 9200 clocks apart.
- R5: A sync rising edge seen while the count is k, with WIN_OPEN (510) <= k <= WIN_CLOSE, resets the counter on the next tick. The `v_reset` interval is then (k+1)*PRE_DIV clocks.
- R6: A sync rising edge seen while the count is below WIN_OPEN (for example 500 or 509) is ignored. The next reset is the forced one at 9200 clocks.
- R7: `v_reset` is high for exactly one clock for each counter reset.
- R8: `retrace` rises with `v_reset` and stays high for RETRACE_TICKS (19) ticks, that is 304 clocks. A new reset during retrace reloads the full length.
- R9: `sync_src` is 1 after a sync-driven reset and 0 after a forced reset. It holds its value until the next reset.
- R10: Sync acceptance is edge based. A sync level that rose before the window opened and stays high through the window does not cause a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock at 32 times the line rate |
| rst | input | 1 | Synchronous active-high reset |
| vsync_in | input | 1 | Digitised vertical sync, asynchronous to `clk` |
| tick_2h | output | 1 | One-clock half-line tick |
| h_out | output | 1 | 50% duty horizontal square wave |
| v_reset | output | 1 | One-clock pulse on every vertical counter reset |
| retrace | output | 1 | High during the vertical retrace interval |
| sync_src | output | 1 | 1 if the latest reset was sync-driven, 0 if forced |

## Verification
The bench places a sync edge at counts 500, 509, 510, 540 and 574. It also holds a sync level high from count 500 onward. For each case it checks the spacing of the reset pulses and the reset cause. A design whose window is off by one count would reset at 509 or would miss 574. A design that resets at once instead of on the next tick would shorten the interval by up to a tick. A design that tests the sync level instead of its edge would lock onto the held level. A wrong source flag would report the 574 sync reset as forced, because it lands on the same tick as the forced reset. The retrace width is measured against 304 clocks, and the tick and horizontal periods are checked on every edge.

// File: rtl/vsync_countdown.sv
module vsync_countdown #(
  parameter int PRE_DIV       = 16,
  parameter int CNT_W         = 10,
  parameter int WIN_OPEN      = 510,
  parameter int WIN_CLOSE     = 574,
  parameter int RETRACE_TICKS = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic vsync_in,
  output logic tick_2h,
  output logic h_out,
  output logic v_reset,
  output logic retrace,
  output logic sync_src
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int RT_W  = $clog2(RETRACE_TICKS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [CNT_W-1:0] OPEN_C   = CNT_W'(WIN_OPEN);
  localparam logic [CNT_W-1:0] CLOSE_C  = CNT_W'(WIN_CLOSE);
  localparam logic [RT_W-1:0]  RT_LOAD  = RT_W'(RETRACE_TICKS);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] vcnt;
  logic [RT_W-1:0]  rt_left;
  logic [2:0]       vs_q;
  logic             pend;
  logic             rise, in_win, hit, forced, fire;

  assign tick_2h = (pre == PRE_LAST);
  assign rise    = vs_q[1] & ~vs_q[2];
  assign in_win  = (vcnt >= OPEN_C);
  assign hit     = tick_2h & (pend | (rise & in_win));
  assign forced  = tick_2h & ~hit & (vcnt == CLOSE_C);
  assign fire    = hit | forced;
  assign retrace = (rt_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre   <= '0;
      h_out <= 1'b0;
    end else begin
      pre <= tick_2h ? '0 : pre + 1'b1;
      if (tick_2h) h_out <= ~h_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vs_q <= '0;
    else     vs_q <= {vs_q[1:0], vsync_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt     <= '0;
      pend     <= 1'b0;
      v_reset  <= 1'b0;
      sync_src <= 1'b0;
    end else begin
      v_reset <= fire;
      if (fire) begin
        vcnt     <= '0;
        sync_src <= hit;
      end else if (tick_2h) begin
        vcnt <= vcnt + 1'b1;
      end
      if (tick_2h)              pend <= 1'b0;
      else if (rise && in_win)  pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        rt_left <= '0;
    else if (fire)                  rt_left <= RT_LOAD;
    else if (tick_2h && retrace)    rt_left <= rt_left - 1'b1;
  end

  a_r1_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick_2h |=> !tick_2h);
  a_r2_hout_after_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(h_out) |-> $past(tick_2h));
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    vcnt <= CLOSE_C);
  a_r6_pending_in_window: assert property (@(posedge clk) disable iff (rst)
    pend |-> in_win);
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
    v_reset |-> (vcnt == '0) && !tick_2h);
  a_r7_reset_single: assert property (@(posedge clk) disable iff (rst)
    v_reset |=> !v_reset);
  a_r8_retrace_starts: assert property (@(posedge clk) disable iff (rst)
    v_reset |-> retrace);
endmodule

// File: tb/vsync_countdown_tb.sv
module vsync_countdown_tb;
  localparam int PRE = 16;
  localparam int FORCED = 575 * PRE;
  localparam int RT_LEN = 19 * PRE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync_in = 1'b0;
  logic tick_2h, h_out, v_reset, retrace, sync_src;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ticks_since = 0;
  int vr_count = 0;
  int vr_cyc = 0;
  int vr_prev = 0;
  int rt_start = 0;
  int rt_len = 0;
  int last_tick = -1;
  int last_edge = -1;
  bit prev_tick = 1'b0;
  bit prev_h = 1'b0;
  bit prev_rt = 1'b0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  vsync_countdown u_dut (
    .clk(clk), .rst(rst), .vsync_in(vsync_in), .tick_2h(tick_2h),
    .h_out(h_out), .v_reset(v_reset), .retrace(retrace), .sync_src(sync_src)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (tick_2h) begin
        if (last_tick >= 0) check(cyc - last_tick == PRE, "R1 tick spacing", cyc - last_tick, PRE);
        last_tick = cyc;
        ticks_since++;
      end
      if (h_out != prev_h) begin
        check(prev_tick, "R2 h_out changes after tick", 0, 1);
        if (last_edge >= 0) check(cyc - last_edge == PRE, "R2 half period", cyc - last_edge, PRE);
        last_edge = cyc;
      end
      if (v_reset) begin
        check(retrace, "R8 retrace starts with v_reset", retrace, 1);
        vr_prev = vr_cyc;
        vr_cyc = cyc;
        vr_count++;
        ticks_since = 0;
        rt_start = cyc;
      end
      if (prev_rt && !retrace) rt_len = cyc - rt_start;
      prev_tick = tick_2h;
      prev_h = h_out;
      prev_rt = retrace;
    end
  end

  task automatic wait_ticks(input int k);
    do begin
      @(posedge clk); #1;
    end while (ticks_since != k);
  endtask

  task automatic wait_vr(input int n0);
    while (vr_count == n0) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic frame(input int k, input bit hold, input int exp_int, input bit exp_src, input string req);
    int n0;
    n0 = vr_count;
    wait_ticks(k);
    vsync_in = 1'b1;
    if (!hold) begin
      repeat (4) @(posedge clk);
      #1 vsync_in = 1'b0;
    end
    wait_vr(n0);
    vsync_in = 1'b0;
    check(vr_cyc - vr_prev == exp_int, {req, " reset interval"}, vr_cyc - vr_prev, exp_int);
    check(sync_src == exp_src, {"R9 source after ", req}, sync_src, exp_src);
    @(posedge clk); #1;
    check(!v_reset, "R7 single-cycle v_reset", v_reset, 0);
  endtask

  initial begin
    int n0;
    repeat (3) @(posedge clk);
    #1;
    check(!tick_2h && !h_out && !v_reset && !retrace && !sync_src, "R3 outputs in reset",
          {tick_2h, h_out, v_reset, retrace, sync_src}, 0);
    rst = 1'b0;
    mon_on = 1'b1;
    @(posedge clk); #1;
    check(!h_out && !v_reset && !retrace && !sync_src, "R3 outputs after reset",
          {h_out, v_reset, retrace, sync_src}, 0);
    wait_vr(0);
    check(sync_src == 1'b0, "R9 first reset forced", sync_src, 0);
    n0 = vr_count;
    wait_vr(n0);
    check(vr_cyc - vr_prev == FORCED, "R4 forced interval", vr_cyc - vr_prev, FORCED);
    check(sync_src == 1'b0, "R9 forced source", sync_src, 0);
    repeat (RT_LEN + 40) @(posedge clk);
    check(rt_len == RT_LEN, "R8 retrace width", rt_len, RT_LEN);
    frame(540, 1'b0, 541 * PRE, 1'b1, "R5 sync at 540");
    frame(500, 1'b0, FORCED, 1'b0, "R6 sync at 500");
    frame(510, 1'b0, 511 * PRE, 1'b1, "R5 sync at window open 510");
    frame(509, 1'b0, FORCED, 1'b0, "R6 sync at 509");
    frame(574, 1'b0, FORCED, 1'b1, "R5 sync at window close 574");
    frame(500, 1'b1, FORCED, 1'b0, "R10 held level");
    frame(520, 1'b0, 521 * PRE, 1'b1, "R5 sync at 520");
    repeat (RT_LEN + 40) @(posedge clk);
    check(rt_len == RT_LEN, "R8 retrace width after sync", rt_len, RT_LEN);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule